// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Drive Sequencer

This block produces the drive pattern for a multiplexed liquid-crystal panel with four backplane (common) lines and twenty segment lines, so that the panel shows up to 80 display bits. It does not generate analog voltages. Every output is a 2-bit level code: low is `2'b00`, mid is `2'b01` and high is `2'b10`. An external level stage turns each code into one of three voltages, which gives the half-bias scheme. Code `2'b11` is never produced.

A frame lasts 1000 clock cycles. With the 75 kHz timing clock that is 75 frames per second. The frame has four slots of 250 cycles each, and in each slot exactly one common line is selected. Polarity flips on every frame so that the panel sees no net DC. Display bits are held in 20 four-bit digit words, one word per segment line, with bit k belonging to common k. The words are written through a digit-addressed strobe port. Two control bits each release a group of four segment lines to general-purpose port use. A backup input and reset drive all level outputs low.

Top module: `lcd_quad_sequencer`

## Requirements
- R1: While reset is active, every common and segment output is `2'b00` and every port-use flag is 0. Both group control bits reset to 0, so every shared line starts as a segment.
- R2: A frame is 1000 cycles split into four consecutive 250-cycle slots, and common k is selected in slot k (k = 0..3). Exactly one common is non-mid at any time while running.
- R3: The selected common drives high (`2'b10`) in even frames and low (`2'b00`) in odd frames, counting from frame 0 after start. Unselected commons drive mid (`2'b01`).
- R4: In each slot a segment line whose bit for the selected common is 1 drives the level opposite to the selected common. A line whose bit is 0 drives the same level as the selected common.
- R5: A write with `wr_en` high stores `wr_data` into digit word `wr_digit`, with bit k belonging to common k. The new value governs the outputs from the second clock edge after the write edge onward.
- R6: A write to a digit address of 20 or more has no effect on any digit word.
- R7: Control bit 0 hands segment lines 12..15 to port use, and control bit 1 does the same for lines 16..19. A handed-over line drives `2'b00` and raises its `seg_gp` flag. A control write takes effect on the second edge after it is sampled. A bit at 0 keeps its four lines as segments.
- R8: While `backup` is sampled high, every level output is `2'b00`, and the digit words and control bits are kept. The first edge after release starts at slot 0 of an even frame.
- R9: Level outputs are registered. The outputs after edge n (n ≥ 1 since start) show timing position n−1, so output slot boundaries lag the counter by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (75 kHz in the target use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup | input | 1 | Holds all levels low and restarts the frame on release |
| wr_en | input | 1 | Digit word write strobe |
| wr_digit | input | 5 | Digit (segment line) address |
| wr_data | input | 4 | Digit word, bit k for common k |
| ctl_wr | input | 1 | Group control write strobe |
| ctl_data | input | 2 | Group control bits (bit0: lines 12..15, bit1: lines 16..19) |
| com_lvl | output | 8 | Common level codes, common k at bits [2k+1:2k] |
| seg_lvl | output | 40 | Segment level codes, line s at bits [2s+1:2s] |
| seg_gp | output | 20 | Per-line flag: line handed to port use |

## Verification
The bench follows every cycle across more than two frames. This exposes an off-by-one slot length or a missing polarity flip, which would shift the selected common or give the wrong rail at the cycle-250/1000 boundaries. Writes to digits 20 and 31 are placed so that an address decoder that truncates or wraps would corrupt digits 4 and 15 with all-ones, which would show up as wrong lit segments. A backup pulse in the middle of a frame checks that the outputs drop at once, that the display words survive, and that the restart begins at slot 0 in even polarity rather than continuing the old count. Each group control bit is toggled alone to catch swapped or misaligned group ranges.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_t;
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
    parameter int SLOT_CLKS = 250,
    parameter int NUM_COM   = 4,
    localparam int CNT_W    = $clog2(SLOT_CLKS),
    localparam int COM_W    = $clog2(NUM_COM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [COM_W-1:0] com_idx,
    output logic             odd_frame
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [COM_W-1:0] com;
        logic             odd;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (s_q.cnt == CNT_W'(SLOT_CLKS - 1)) begin
            s_d.cnt = '0;
            if (s_q.com == COM_W'(NUM_COM - 1)) begin
                s_d.com = '0;
                s_d.odd = ~s_q.odd;
            end else begin
                s_d.com = s_q.com + 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign com_idx   = s_q.com;
    assign odd_frame = s_q.odd;
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int NUM_SEG  = 20,
    parameter int NUM_COM  = 4,
    localparam int DIG_W   = $clog2(NUM_SEG),
    localparam int BITS    = NUM_SEG * NUM_COM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DIG_W-1:0]   wr_digit,
    input  logic [NUM_COM-1:0] wr_data,
    output logic [BITS-1:0]    mem
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [DIG_W-1:0] LAST_DIG = DIG_W'(NUM_SEG - 1);

    logic [BITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (wr_digit <= LAST_DIG)) begin
            mem_d[int'(wr_digit) * NUM_COM +: NUM_COM] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign mem = mem_q;
endmodule

// File: rtl/lcd_drive_enc.sv
module lcd_drive_enc
    import lcd_pkg::*;
#(
    parameter int NUM_SEG = 20,
    parameter int NUM_COM = 4,
    localparam int COM_W  = $clog2(NUM_COM)
) (
    input  logic [COM_W-1:0]           com_idx,
    input  logic                       odd_frame,
    input  logic [NUM_SEG*NUM_COM-1:0] mem,
    input  logic [NUM_SEG-1:0]         gp_mask,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);
    timeunit 1ns;
    timeprecision 1ps;

    lvl_t sel_lvl, opp_lvl;

    always_comb begin
        sel_lvl = odd_frame ? LVL_LOW  : LVL_HIGH;
        opp_lvl = odd_frame ? LVL_HIGH : LVL_LOW;
        for (int c = 0; c < NUM_COM; c++) begin
            com_lvl[2*c +: 2] = (COM_W'(c) == com_idx) ? sel_lvl : LVL_MID;
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            if (gp_mask[s])
                seg_lvl[2*s +: 2] = LVL_LOW;
            else if (mem[s*NUM_COM + int'(com_idx)])
                seg_lvl[2*s +: 2] = opp_lvl;
            else
                seg_lvl[2*s +: 2] = sel_lvl;
        end
    end
endmodule

// File: rtl/lcd_quad_sequencer.sv
module lcd_quad_sequencer #(
    parameter int NUM_SEG     = 20,
    parameter int NUM_COM     = 4,
    parameter int FRAME_CLKS  = 1000,
    parameter int SHARED_BASE = 12,
    parameter int GROUP_W     = 4,
    parameter int NUM_GROUPS  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       backup,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_SEG)-1:0] wr_digit,
    input  logic [NUM_COM-1:0]         wr_data,
    input  logic                       ctl_wr,
    input  logic [NUM_GROUPS-1:0]      ctl_data,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl,
    output logic [NUM_SEG-1:0]         seg_gp
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SLOT_CLKS = FRAME_CLKS / NUM_COM;
    localparam int COM_W     = $clog2(NUM_COM);

    typedef struct packed {
        logic [2*NUM_COM-1:0]  com;
        logic [2*NUM_SEG-1:0]  seg;
        logic [NUM_SEG-1:0]    gp;
        logic [NUM_GROUPS-1:0] ctl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [COM_W-1:0]           com_idx;
    logic                       odd_frame;
    logic [NUM_SEG*NUM_COM-1:0] mem;
    logic [NUM_SEG-1:0]         gp_mask;
    logic [2*NUM_COM-1:0]       enc_com;
    logic [2*NUM_SEG-1:0]       enc_seg;

    lcd_timebase #(.SLOT_CLKS(SLOT_CLKS), .NUM_COM(NUM_COM)) u_timebase (
        .clk(clk), .rst_n(rst_n), .clear(backup),
        .com_idx(com_idx), .odd_frame(odd_frame)
    );

    lcd_disp_ram #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_digit(wr_digit), .wr_data(wr_data), .mem(mem)
    );

    lcd_drive_enc #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_enc (
        .com_idx(com_idx), .odd_frame(odd_frame), .mem(mem),
        .gp_mask(gp_mask), .com_lvl(enc_com), .seg_lvl(enc_seg)
    );

    // Group g covers lines SHARED_BASE+g*GROUP_W .. +GROUP_W-1
    always_comb begin
        gp_mask = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int k = 0; k < GROUP_W; k++) begin
                if (st_q.ctl[g]) gp_mask[SHARED_BASE + g*GROUP_W + k] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.gp  = gp_mask;
        st_d.com = backup ? '0 : enc_com;
        st_d.seg = backup ? '0 : enc_seg;
        if (ctl_wr) st_d.ctl = ctl_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_lvl = st_q.com;
    assign seg_lvl = st_q.seg;
    assign seg_gp  = st_q.gp;
endmodule

// File: rtl/lcd_quad_sequencer_chk.sv
module lcd_quad_sequencer_chk #(
    parameter int NUM_SEG = 20,
    parameter int NUM_COM = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 backup,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [NUM_SEG-1:0]   seg_gp
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                 bad_code;
    logic                 seg_mid;
    int                   mid_cnt;
    logic [2*NUM_SEG-1:0] gp_wide;

    always_comb begin
        bad_code = 1'b0;
        seg_mid  = 1'b0;
        mid_cnt  = 0;
        for (int c = 0; c < NUM_COM; c++) begin
            if (com_lvl[2*c +: 2] == 2'b11) bad_code = 1'b1;
            if (com_lvl[2*c +: 2] == 2'b01) mid_cnt = mid_cnt + 1;
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            if (seg_lvl[2*s +: 2] == 2'b11) bad_code = 1'b1;
            if (seg_lvl[2*s +: 2] == 2'b01) seg_mid = 1'b1;
            gp_wide[2*s +: 2] = {2{seg_gp[s]}};
        end
    end

    assert_no_reserved_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code);

    assert_single_selected_common_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl != '0) |-> (mid_cnt == NUM_COM - 1));

    assert_backup_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(backup) |-> (com_lvl == '0 && seg_lvl == '0));

    assert_port_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_lvl & gp_wide) == '0);

    assert_segment_two_rails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl != '0) |-> !seg_mid);
endmodule

bind lcd_quad_sequencer lcd_quad_sequencer_chk #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_chk (
    .clk(clk), .rst_n(rst_n), .backup(backup),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .seg_gp(seg_gp)
);

// File: tb/lcd_quad_sequencer_tb.sv
module lcd_quad_sequencer_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        backup = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_digit = '0;
    logic [3:0]  wr_data = '0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_data = '0;
    logic [7:0]  com_lvl;
    logic [39:0] seg_lvl;
    logic [19:0] seg_gp;

    always #5 clk = ~clk;

    lcd_quad_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .backup(backup),
        .wr_en(wr_en), .wr_digit(wr_digit), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .seg_gp(seg_gp)
    );

    typedef struct {
        logic [7:0]  com;
        logic [39:0] seg;
        logic [19:0] gp;
        string       tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    int          total = 0;
    int          bad = 0;
    int          nedge = 0;
    logic [3:0]  shadow [20];
    logic [1:0]  ctl_sh = '0;
    string       cur_tag = "R1 reset";

    // edges since the last reset/backup release (R8, R9)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)      nedge <= 0;
        else if (backup) nedge <= 0;
        else             nedge <= nedge + 1;
    end

    function automatic exp_item_t build_exp(int n);
        exp_item_t it;
        logic [1:0] sel, opp;
        int idx, c;
        it.tag = cur_tag;
        it.com = '0;
        it.seg = '0;
        it.gp  = '0;
        for (int s = 12; s < 16; s++) it.gp[s] = ctl_sh[0];
        for (int s = 16; s < 20; s++) it.gp[s] = ctl_sh[1];
        if (n > 0) begin
            idx = n - 1;
            c   = (idx / 250) % 4;
            sel = ((idx / 1000) % 2 == 1) ? 2'b00 : 2'b10;
            opp = (sel == 2'b10) ? 2'b00 : 2'b10;
            for (int k = 0; k < 4; k++) it.com[2*k +: 2] = (k == c) ? sel : 2'b01;
            for (int s = 0; s < 20; s++) begin
                if (it.gp[s])             it.seg[2*s +: 2] = 2'b00;
                else if (shadow[s][c])    it.seg[2*s +: 2] = opp;
                else                      it.seg[2*s +: 2] = sel;
            end
        end
        return it;
    endfunction

    // driver side: one expectation per cycle
    task automatic tick();
        @(negedge clk);
        sb_q.push_back(build_exp(nedge));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_digit(input int d, input logic [3:0] v);
        wr_en = 1'b1; wr_digit = d[4:0]; wr_data = v;
        tick();
        wr_en = 1'b0;
        if (d < 20) shadow[d] = v;
    endtask

    task automatic write_ctl(input logic [1:0] v);
        ctl_wr = 1'b1; ctl_data = v;
        tick();
        ctl_wr = 1'b0;
        ctl_sh = v;
    endtask

    // monitor side: pop and compare
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            total++;
            if (com_lvl !== it.com) begin
                bad++;
                $display("FAIL %s com_lvl act=%h exp=%h", it.tag, com_lvl, it.com);
            end
            total++;
            if (seg_lvl !== it.seg) begin
                bad++;
                $display("FAIL %s seg_lvl act=%h exp=%h", it.tag, seg_lvl, it.seg);
            end
            total++;
            if (seg_gp !== it.gp) begin
                bad++;
                $display("FAIL %s seg_gp act=%h exp=%h", it.tag, seg_gp, it.gp);
            end
        end
    end

    initial begin
        for (int s = 0; s < 20; s++) shadow[s] = 4'h0;
        #200_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_tag = "R1 reset";
        ticks(3);
        rst_n = 1'b1;
        backup = 1'b1;
        cur_tag = "R8 backup hold";
        ticks(3);
        cur_tag = "R5 load";
        for (int s = 0; s < 20; s++) write_digit(s, 4'((s*5 + 9) % 16));
        cur_tag = "R6 ignored digit";
        write_digit(20, 4'hF);
        write_digit(31, 4'hF);
        ticks(2);
        backup = 1'b0;
        cur_tag = "R2 R3 R4 R6 R9 sequence";
        ticks(2100);
        cur_tag = "R5 rewrite";
        write_digit(7, ~shadow[7]);
        write_digit(0, 4'hF);
        ticks(300);
        cur_tag = "R7 port share";
        write_ctl(2'b01);
        ticks(260);
        write_ctl(2'b10);
        ticks(260);
        write_ctl(2'b11);
        ticks(10);
        write_ctl(2'b00);
        ticks(10);
        cur_tag = "R8 mid-frame backup";
        ticks(137);
        backup = 1'b1;
        ticks(5);
        backup = 1'b0;
        ticks(1100);
        @(negedge clk);
        #2;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule